// File: doc/BRIEF.md
# Timed Power Rail Sequencer

This block brings up a group of power rails and a system reset in a fixed order, then takes them down in the reverse order. A single up/down timer advances once per slow tick (nominally 1 ms each). Five channel comparators each hold a programmable delay of 0 to 63 ticks. While the timer climbs, each comparator raises its output once the timer has passed its delay. While the timer falls, each comparator drops its output once the timer has come down to its delay. The power-off order is therefore the power-on order reversed, and no rail needs a timer of its own.

A power-on request is accepted only when everything is off. It starts a fixed settling wait of five ticks, and the up-count begins when that wait ends. A power-off request turns the timer around from wherever it stands. A power-on request during power-off turns it around again. Every output is a register that changes only on a tick cycle. A one-cycle done pulse marks the end of a full up-count or down-count.

Typical delay sets are {5, 15, 20, 25, 60} and {6, 3, 1, 0, 10}. They are listed in channel order: linear pair, converter 1, converter 2, converter 3, reset.

Top module: `pwr_rail_seq`

## Requirements
- R1: Reset (synchronous, active high) clears all four rail enables, drives `sys_rst_n` low, holds `seq_done` low and sets the timer to 0. Everything stays off until a power-on request arrives.
- R2: A power-on request accepted from the off state starts a settling wait of 5 ticks, during which all outputs stay low. A power-off request during the wait returns the block to the off state, and a later power-on request restarts the full wait.
- R3: On the up-count, the output of a channel with delay d rises on tick d+1 after the settling wait ends. It then stays high until a power-off request arrives.
- R4: From the fully-on state, a power-off request makes the output of a channel with delay d fall on tick 64-d after the request. The rails therefore drop in the reverse order of power-on.
- R5: The timer saturates at 63 going up and at 0 going down and never wraps. A delay of 63 rises on up-tick 64 and falls on the first down-tick. A delay of 0 rises on the first up-tick and falls on down-tick 64.
- R6: `seq_done` is high for exactly one clock cycle. It pulses on the tick that completes an up-count (timer already at 63) and on the tick that completes a down-count (timer already at 0). It stays low at all other times.
- R7: A power-off request during the up-count, after u up-ticks, reverses the timer from u. A channel that is on falls on down-tick u+1-d, and done pulses on down-tick u+1.
- R8: A power-on request during the down-count, with the timer at v, reverses the timer upward from v. A channel that is off rises on the up-tick where the timer before the step reaches d. Done pulses on up-tick 64-v.
- R9: These requests have no effect: a power-on request while fully on or counting up, and a power-off request while off or counting down. A request cycle with both requests high counts as a power-off request.
- R10: The outputs change only in a clock cycle in which `tick_1k` is high. Within one counting phase, enables only rise on the way up and only fall on the way down.
- R11: Channel 0 (`dly_lin`) drives `rail_en[0]`, the shared enable of the two linear regulators. Channels 1 to 3 drive `rail_en[1]` to `rail_en[3]`, one per switching converter. Channel 4 drives `sys_rst_n`, which is high while its channel is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1k | input | 1 | One-cycle tick enable, one per timer step |
| pwr_on_req | input | 1 | Deglitched power-on request |
| pwr_off_req | input | 1 | Deglitched power-off request |
| dly_lin | input | 6 | Delay of the linear-regulator pair channel |
| dly_cv1 | input | 6 | Delay of switching converter 1 |
| dly_cv2 | input | 6 | Delay of switching converter 2 |
| dly_cv3 | input | 6 | Delay of switching converter 3 |
| dly_rst | input | 6 | Delay of the reset channel |
| rail_en | output | 4 | Rail enables: bit 0 linear pair, bits 1 to 3 converters |
| sys_rst_n | output | 1 | Active-low system reset output |
| seq_done | output | 1 | One-cycle pulse when a full up- or down-count completes |

## Verification
The bench aims at the ends of the delay range. With a delay of 0 or 63, an off-by-one in a comparator or a wrapping timer would show up as a rail switching one tick early or late, or never switching at all. It reverses direction at random points in both phases. A design that restarted the count from an end value instead of the current one would switch every rail at the wrong tick and would place the done pulse wrongly. It also sends requests that must be ignored, simultaneous requests, and an abort during the settling wait. A design that misread any of these would switch rails with no valid cause, or would skip part of the settling wait.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_SETTLE = 3'd1,
    PS_UP     = 3'd2,
    PS_ON     = 3'd3,
    PS_DOWN   = 3'd4
  } pseq_state_t;

endpackage

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [CNT_W-1:0] cnt,
  output logic             at_top,
  output logic             at_bot
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assign at_top = (cnt == TOP);
  assign at_bot = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step_up && !at_top) begin
      cnt <= cnt + 1'b1;
    end else if (step_dn && !at_bot) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R5: saturation at both ends
  a_r5_hold_top: assert property (@(posedge clk) disable iff (rst)
    (at_top && step_up && !step_dn) |=> at_top);
  a_r5_hold_bot: assert property (@(posedge clk) disable iff (rst)
    (at_bot && step_dn && !step_up) |=> at_bot);

endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int SETTLE_TICKS = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        on_req,
  input  logic        off_req,
  input  logic        at_top,
  input  logic        at_bot,
  output pseq_state_t st,
  output logic        step_up,
  output logic        step_dn,
  output logic        done
);

  localparam int SW = $clog2(SETTLE_TICKS + 1);
  localparam logic [SW-1:0] LAST = SW'(SETTLE_TICKS - 1);

  logic [SW-1:0] sc;
  logic          on_only;

  assign on_only = on_req && !off_req;
  assign step_up = (st == PS_UP) && tick && !off_req;
  assign step_dn = (st == PS_DOWN) && tick && !on_only;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= PS_OFF;
      sc   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        PS_OFF: begin
          if (on_only) begin
            st <= PS_SETTLE;
            sc <= '0;
          end
        end
        PS_SETTLE: begin
          if (off_req) begin
            st <= PS_OFF;
            sc <= '0;
          end else if (tick) begin
            if (sc == LAST) begin
              st <= PS_UP;
              sc <= '0;
            end else begin
              sc <= sc + 1'b1;
            end
          end
        end
        PS_UP: begin
          if (off_req) begin
            st <= PS_DOWN;
          end else if (tick && at_top) begin
            st   <= PS_ON;
            done <= 1'b1;
          end
        end
        PS_ON: begin
          if (off_req) st <= PS_DOWN;
        end
        PS_DOWN: begin
          if (on_only) begin
            st <= PS_UP;
          end else if (tick && at_bot) begin
            st   <= PS_OFF;
            done <= 1'b1;
          end
        end
        default: st <= PS_OFF;
      endcase
    end
  end

  // R2: settling count never passes its last value
  a_r2_settle_range: assert property (@(posedge clk) disable iff (rst)
    sc <= LAST);
  // R6: done only lands in a resting state
  a_r6_done_rest: assert property (@(posedge clk) disable iff (rst)
    done |-> (st == PS_ON || st == PS_OFF));
  // R6: done lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/pseq_chan.sv
module pseq_chan #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] dly,
  output logic             en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0;
    end else if (step_up) begin
      en <= en | (cnt >= dly);
    end else if (step_dn) begin
      en <= en & (cnt > dly);
    end
  end

  // R3: no falling edge while stepping up
  a_r3_up_no_fall: assert property (@(posedge clk) disable iff (rst)
    step_up |=> !($past(en) && !en));
  // R4: no rising edge while stepping down
  a_r4_dn_no_rise: assert property (@(posedge clk) disable iff (rst)
    step_dn |=> !(!$past(en) && en));

endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
  import pwrseq_pkg::*;
#(
  parameter int CNT_W        = 6,
  parameter int SETTLE_TICKS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_1k,
  input  logic             pwr_on_req,
  input  logic             pwr_off_req,
  input  logic [CNT_W-1:0] dly_lin,
  input  logic [CNT_W-1:0] dly_cv1,
  input  logic [CNT_W-1:0] dly_cv2,
  input  logic [CNT_W-1:0] dly_cv3,
  input  logic [CNT_W-1:0] dly_rst,
  output logic [3:0]       rail_en,
  output logic             sys_rst_n,
  output logic             seq_done
);

  localparam int NCH = 5;

  pseq_state_t      st;
  logic             step_up, step_dn, at_top, at_bot;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dly_arr [NCH];
  logic [NCH-1:0]   en_all;

  assign dly_arr[0] = dly_lin;
  assign dly_arr[1] = dly_cv1;
  assign dly_arr[2] = dly_cv2;
  assign dly_arr[3] = dly_cv3;
  assign dly_arr[4] = dly_rst;

  pseq_ctrl #(.SETTLE_TICKS(SETTLE_TICKS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_1k),
    .on_req  (pwr_on_req),
    .off_req (pwr_off_req),
    .at_top  (at_top),
    .at_bot  (at_bot),
    .st      (st),
    .step_up (step_up),
    .step_dn (step_dn),
    .done    (seq_done)
  );

  pseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .step_up (step_up),
    .step_dn (step_dn),
    .cnt     (cnt),
    .at_top  (at_top),
    .at_bot  (at_bot)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pseq_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .step_up (step_up),
      .step_dn (step_dn),
      .cnt     (cnt),
      .dly     (dly_arr[g]),
      .en      (en_all[g])
    );
  end

  assign rail_en   = en_all[3:0];
  assign sys_rst_n = en_all[4];

  // R10: outputs move only on tick cycles
  a_r10_tick_only: assert property (@(posedge clk) disable iff (rst)
    !tick_1k |=> $stable(en_all));
  // R1: the off state is fully quiet
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == PS_OFF) |-> (en_all == '0 && cnt == '0));
  // R2: nothing turns on during the settling wait
  a_r2_settle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == PS_SETTLE) |-> (en_all == '0));

endmodule

// File: tb/test_pwr_rail_seq.sv
`timescale 1ns/1ps
module test_pwr_rail_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       on_req = 1'b0;
  logic       off_req = 1'b0;
  logic [5:0] dly [0:4];
  logic [3:0] rail_en;
  logic       sys_rst_n;
  logic       seq_done;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;
  int  b_tmr;
  logic [4:0] b_en;

  always #10 clk = ~clk;

  pwr_rail_seq i_pwr_rail_seq (
    .clk(clk), .rst(rst), .tick_1k(tick),
    .pwr_on_req(on_req), .pwr_off_req(off_req),
    .dly_lin(dly[0]), .dly_cv1(dly[1]), .dly_cv2(dly[2]),
    .dly_cv3(dly[3]), .dly_rst(dly[4]),
    .rail_en(rail_en), .sys_rst_n(sys_rst_n), .seq_done(seq_done)
  );

  task automatic chk(string tag, logic [4:0] exp_en, logic exp_done);
    logic [5:0] act, exp;
    act = {seq_done, sys_rst_n, rail_en};
    exp = {exp_done, exp_en};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (done,rst_n,rails)", tag, act, exp);
    end
  endtask

  task automatic gap();
    int g = int'($urandom_range(0, 2));
    for (int i = 0; i < g; i++) begin
      @(negedge clk);
      chk("R10", b_en, 1'b0);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic req(bit on, bit off);
    @(negedge clk) begin on_req = on; off_req = off; end
    @(negedge clk) begin on_req = 1'b0; off_req = 1'b0; end
  endtask

  // up-count from timer v with enables en0
  task automatic run_up(string tag, int v, logic [4:0] en0, int n);
    logic [4:0] e;
    for (int k = 1; k <= n; k++) begin
      int t = v + k - 1;
      if (t > 63) t = 63;
      for (int i = 0; i < 5; i++) e[i] = en0[i] | (t >= int'(dly[i]));
      do_tick();
      chk(tag, e, k == 64 - v);
      b_en = e;
      gap();
    end
    b_tmr = (v + n > 63) ? 63 : v + n;
  endtask

  // down-count from timer u with enables en0
  task automatic run_dn(string tag, int u, logic [4:0] en0, int n);
    logic [4:0] e;
    for (int k = 1; k <= n; k++) begin
      for (int i = 0; i < 5; i++) e[i] = en0[i] & ((u - k + 1) > int'(dly[i]));
      do_tick();
      chk(tag, e, k == u + 1);
      b_en = e;
      gap();
    end
    b_tmr = (u - n < 0) ? 0 : u - n;
  endtask

  task automatic settle();
    req(1'b1, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      do_tick();
      chk("R2", 5'b0, 1'b0);
    end
  endtask

  task automatic full_on(string tag);
    settle();
    run_up(tag, 0, 5'b0, 64);
  endtask

  task automatic set_dly(int a, int b, int c, int d, int e);
    dly[0] = 6'(a); dly[1] = 6'(b); dly[2] = 6'(c); dly[3] = 6'(d); dly[4] = 6'(e);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    set_dly(5, 15, 20, 25, 60);
    b_en = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", 5'b0, 1'b0);
    do_tick();
    chk("R1", 5'b0, 1'b0);

    // standard delay set: R3 order, R11 mapping, R4 reverse
    full_on("R3");
    chk("R11", 5'b11111, 1'b0);
    req(1'b0, 1'b1);
    run_dn("R4", 63, 5'b11111, 64);

    // alternate delay set
    set_dly(6, 3, 1, 0, 10);
    full_on("R3");
    req(1'b0, 1'b1);
    run_dn("R4", 63, 5'b11111, 64);

    // extremes of the delay range
    set_dly(0, 63, 1, 62, 32);
    full_on("R5");
    do_tick();
    chk("R5", 5'b11111, 1'b0);
    req(1'b1, 1'b0);           // ignored while on
    do_tick();
    chk("R9", 5'b11111, 1'b0);
    req(1'b0, 1'b1);
    run_dn("R5", 63, 5'b11111, 64);
    do_tick();
    chk("R6", 5'b0, 1'b0);

    // ignored off request and simultaneous requests in the off state
    req(1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin do_tick(); chk("R9", 5'b0, 1'b0); end
    req(1'b1, 1'b1);
    for (int k = 0; k < 8; k++) begin do_tick(); chk("R9", 5'b0, 1'b0); end

    // abort during the settling wait, then a full restart
    req(1'b1, 1'b0);
    do_tick(); chk("R2", 5'b0, 1'b0);
    do_tick(); chk("R2", 5'b0, 1'b0);
    req(1'b0, 1'b1);
    for (int k = 0; k < 8; k++) begin do_tick(); chk("R2", 5'b0, 1'b0); end
    full_on("R2");
    // on request during up-count ignored is covered below; go down
    req(1'b0, 1'b1);
    run_dn("R4", 63, 5'b11111, 64);

    // on request during up-count and off request during down-count are ignored
    settle();
    run_up("R3", 0, 5'b0, 10);
    req(1'b1, 1'b0);
    run_up("R9", b_tmr, b_en, 64 - b_tmr);
    req(1'b0, 1'b1);
    run_dn("R4", 63, 5'b11111, 20);
    req(1'b0, 1'b1);
    run_dn("R9", b_tmr, b_en, b_tmr + 1);

    // random delays and random reversal points
    for (int it = 0; it < 10; it++) begin
      int u, m;
      for (int i = 0; i < 5; i++) begin
        int r = int'($urandom_range(0, 9));
        dly[i] = (r == 0) ? 6'd0 : (r == 1) ? 6'd63 : 6'($urandom_range(0, 63));
      end
      u = int'($urandom_range(1, 62));
      settle();
      run_up("R3", 0, 5'b0, u);
      req(1'b0, 1'b1);
      run_dn("R7", u, b_en, u + 1);
      full_on("R3");
      m = int'($urandom_range(1, 63));
      req(1'b0, 1'b1);
      run_dn("R4", 63, 5'b11111, m);
      req(1'b1, 1'b0);
      run_up("R8", b_tmr, b_en, 64 - b_tmr);
      req(1'b0, 1'b1);
      run_dn("R4", 63, 5'b11111, 64);
    end

    // reset in the middle of a sequence
    set_dly(5, 15, 20, 25, 60);
    settle();
    run_up("R3", 0, 5'b0, 30);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    b_en = '0;
    chk("R1", 5'b0, 1'b0);
    full_on("R1");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule